// File: doc/BRIEF.md
# Management-Register-over-I2C Sequencer

This block sits between a host that issues PHY management register accesses and a byte-level I2C engine. Each accepted request is turned into an ordered list of byte commands (bus start, repeated start, byte write, byte read with acknowledge or not-acknowledge, bus stop). The I2C target address is derived from the 5-bit PHY address. The command list depends on two things: whether the request is a read or a write, and whether it uses short (clause-22) or extended (clause-45) register addressing.

For reads, the two returned bytes are assembled into a 16-bit result. When any address or data byte is refused by the target, the sequencer abandons the remaining bytes and closes the bus with a stop. Reads then report all ones, and both reads and writes raise the error flag. Two PHY addresses alias the pluggable module's EEPROM. Requests to them complete at once with no bus activity at all.

The byte engine below this block handles SCL/SDA bit timing. Clock stretching and arbitration also belong to the engine.

Top module: `mdio_i2c_xlate`

## Requirements
- R1: The byte written right after a bus start is `{phy+7'h40, 1'b0}`, and the byte written right after a repeated start is `{phy+7'h40, 1'b1}` (7-bit target address in bits 7:1, read flag in bit 0).
- R2: A request to PHY address 5'h10 or 5'h11 issues no command. `done` rises in the cycle after acceptance with `err`=0. `rdata` is 16'hFFFF for a read.
- R3: A short-format read issues, in order: START, WRITE addr, WRITE reg[7:0], RESTART, WRITE addr|1, READ_ACK, READ_NACK, STOP.
- R4: An extended-format read issues, in order: START, WRITE addr, WRITE {3'b001,dev}, WRITE reg[15:8], WRITE reg[7:0], RESTART, WRITE addr|1, READ_ACK, READ_NACK, STOP.
- R5: A short-format write issues, in order: START, WRITE addr, WRITE reg[7:0], WRITE data[15:8], WRITE data[7:0], STOP.
- R6: An extended-format write issues, in order: START, WRITE addr, WRITE {3'b000,dev}, WRITE reg[15:8], WRITE reg[7:0], WRITE data[15:8], WRITE data[7:0], STOP.
- R7: A successful read reports `rdata` = {first byte returned, second byte returned} with `err`=0. A successful write reports `err`=0 and `rdata`=0.
- R8: A not-acknowledge on any WRITE command makes the next command a STOP, with no further bytes. The request then completes with `err`=1, and with `rdata`=16'hFFFF for a read or 0 for a write.
- R9: `req_ready` is high only while idle. `done` is a single-cycle pulse. A command offered with `cmd_valid` holds its op and byte until `cmd_ready`. Command op codes are START=0, RESTART=1, WRITE=2, READ_ACK=3, READ_NACK=4, STOP=5.
- R10: After reset, `req_ready`=1, `done`=0, `err`=0, `rdata`=0 and `cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = extended addressing |
| req_phy | input | 5 | PHY address |
| req_dev | input | 5 | Device address (extended only) |
| req_reg | input | 16 | Register number |
| req_wdata | input | 16 | Write data |
| done | output | 1 | Completion pulse |
| err | output | 1 | Failure flag, valid with done |
| rdata | output | 16 | Read result, valid with done |
| cmd_valid | output | 1 | Byte command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte to write |
| rsp_valid | input | 1 | Engine reports command finished |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| rsp_byte | input | 8 | Byte read |

## Verification
Two functions can land on the same response: the engine's report of a finished address or data byte and the sequencer's decision on what comes next. When that report carries a not-acknowledge, the sequencer has to drop the planned next byte and issue a stop instead. The bench provokes this by injecting a not-acknowledge at every WRITE position of every framing. It judges the result by comparing the logged command list with the expected list truncated after the refused byte plus a STOP, and by checking the error flag and the forced read result.

// File: rtl/mdio_i2c_xlate.sv
module mdio_i2c_xlate #(
  parameter int PHY_W = 5,
  parameter int REG_W = 16,
  parameter logic [6:0] ADDR_BASE = 7'h40,
  parameter logic [PHY_W-1:0] BLOCK_A = 5'h10,
  parameter logic [PHY_W-1:0] BLOCK_B = 5'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_c45,
  input  logic [PHY_W-1:0] req_phy,
  input  logic [4:0]       req_dev,
  input  logic [REG_W-1:0] req_reg,
  input  logic [15:0]      req_wdata,
  output logic             done,
  output logic             err,
  output logic [15:0]      rdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_byte
);
  localparam logic [2:0] OP_START = 3'd0, OP_RESTART = 3'd1, OP_WRITE = 3'd2,
                         OP_RDACK = 3'd3, OP_RDNACK = 3'd4, OP_STOP = 3'd5;
  localparam logic [3:0] S_LAST = 4'd9;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT, FIN} st_t;
  st_t st;

  logic             w_q, c45_q;
  logic [PHY_W-1:0] phy_q;
  logic [4:0]       dev_q;
  logic [REG_W-1:0] reg_q;
  logic [15:0]      wd_q;
  logic [3:0]       slot;
  logic [6:0]       taddr;

  assign taddr     = ADDR_BASE + 7'(phy_q);
  assign req_ready = (st == IDLE);
  assign done      = (st == FIN);
  assign cmd_valid = (st == ISSUE);

  function automatic logic [3:0] next_slot(input logic [3:0] s, input logic w, input logic c45);
    case (s)
      4'd1:    next_slot = c45 ? 4'd2 : 4'd4;
      4'd6:    next_slot = w ? S_LAST : 4'd7;
      default: next_slot = s + 4'd1;
    endcase
  endfunction

  always_comb begin
    cmd_op   = OP_WRITE;
    cmd_byte = 8'h00;
    case (slot)
      4'd0: cmd_op = OP_START;
      4'd1: cmd_byte = {taddr, 1'b0};
      4'd2: cmd_byte = {2'b00, ~w_q, dev_q};
      4'd3: cmd_byte = reg_q[15:8];
      4'd4: cmd_byte = reg_q[7:0];
      4'd5: if (w_q) cmd_byte = wd_q[15:8]; else cmd_op = OP_RESTART;
      4'd6: cmd_byte = w_q ? wd_q[7:0] : {taddr, 1'b1};
      4'd7: cmd_op = OP_RDACK;
      4'd8: cmd_op = OP_RDNACK;
      default: cmd_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      slot  <= 4'd0;
      err   <= 1'b0;
      rdata <= 16'h0000;
      w_q   <= 1'b0;
      c45_q <= 1'b0;
      phy_q <= '0;
      dev_q <= '0;
      reg_q <= '0;
      wd_q  <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          w_q   <= req_write;
          c45_q <= req_c45;
          phy_q <= req_phy;
          dev_q <= req_dev;
          reg_q <= req_reg;
          wd_q  <= req_wdata;
          slot  <= 4'd0;
          err   <= 1'b0;
          rdata <= req_write ? 16'h0000 : 16'hFFFF;
          st    <= (req_phy == BLOCK_A || req_phy == BLOCK_B) ? FIN : ISSUE;
        end
        ISSUE: if (cmd_ready) st <= WAIT;
        WAIT: if (rsp_valid) begin
          if (slot == S_LAST) begin
            st <= FIN;
          end else if (rsp_nack && cmd_op == OP_WRITE) begin
            err  <= 1'b1;
            if (!w_q) rdata <= 16'hFFFF;
            slot <= S_LAST;
            st   <= ISSUE;
          end else begin
            if (slot == 4'd7) rdata[15:8] <= rsp_byte;
            if (slot == 4'd8) rdata[7:0]  <= rsp_byte;
            slot <= next_slot(slot, w_q, c45_q);
            st   <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module mdio_i2c_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [4:0] req_phy,
  input logic       done,
  input logic       err,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       rsp_valid,
  input logic       rsp_nack
);
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && !req_ready);
  a_r2_blocked_phy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_phy == 5'h10 || req_phy == 5'h11) |=> done && !cmd_valid && !err);
  a_r8_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_nack && !cmd_valid && cmd_op == 3'd2 |=> cmd_valid && cmd_op == 3'd5);
endmodule

bind mdio_i2c_xlate mdio_i2c_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_phy(req_phy), .done(done), .err(err), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
  .rsp_valid(rsp_valid), .rsp_nack(rsp_nack)
);

// File: tb/mdio_i2c_xlate_tb.sv
module mdio_i2c_xlate_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_c45 = 0;
  logic [4:0] req_phy = 0, req_dev = 0;
  logic [15:0] req_reg = 0, req_wdata = 0;
  logic req_ready, done, err, cmd_valid;
  logic [15:0] rdata;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic cmd_ready = 0, rsp_valid = 0, rsp_nack = 0;
  logic [7:0] rsp_byte = 0;

  mdio_i2c_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_c45(req_c45), .req_phy(req_phy), .req_dev(req_dev),
    .req_reg(req_reg), .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte));

  int tests = 0, fails = 0;
  int log_n = 0, nack_at = -1;
  logic [2:0] log_op [16];
  logic [7:0] log_b  [16];
  logic [2:0] pend_op;
  logic [7:0] pend_b;
  logic [7:0] eng_hi = 0, eng_lo = 0;
  int exp_n;
  logic [2:0] exp_op [16];
  logic [7:0] exp_b  [16];

  // byte engine model
  initial forever begin
    @(negedge clk);
    rsp_valid = 0; rsp_nack = 0;
    if (cmd_ready) begin
      cmd_ready = 0;
      rsp_valid = 1;
      rsp_byte  = (pend_op == 3'd3) ? eng_hi : (pend_op == 3'd4) ? eng_lo : 8'h00;
      rsp_nack  = (log_n == nack_at) && (pend_op == 3'd2);
      if (log_n < 16) begin log_op[log_n] = pend_op; log_b[log_n] = pend_b; end
      log_n++;
    end else if (cmd_valid) begin
      cmd_ready = 1;
      pend_op = cmd_op;
      pend_b  = cmd_byte;
    end
  end

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog: run did not finish (actual hung, expected complete)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic build_exp(input bit w, input bit c45, input logic [4:0] phy,
                           input logic [4:0] dev, input logic [15:0] rg, input logic [15:0] wd);
    logic [6:0] ta;
    ta = 7'h40 + {2'b00, phy};
    exp_n = 0;
    push(3'd0, 8'h00);
    push(3'd2, {ta, 1'b0});
    if (c45) begin
      push(3'd2, w ? {3'b000, dev} : {3'b001, dev});
      push(3'd2, rg[15:8]);
    end
    push(3'd2, rg[7:0]);
    if (w) begin
      push(3'd2, wd[15:8]);
      push(3'd2, wd[7:0]);
    end else begin
      push(3'd1, 8'h00);
      push(3'd2, {ta, 1'b1});
      push(3'd3, 8'h00);
      push(3'd4, 8'h00);
    end
    push(3'd5, 8'h00);
  endtask

  task automatic run(input bit w, input bit c45, input logic [4:0] phy, input logic [4:0] dev,
                     input logic [15:0] rg, input logic [15:0] wd, input int nk, input string tag);
    int cyc;
    bit blocked, failed, seq_ok;
    logic [15:0] exp_rd;
    blocked = (phy == 5'h10) || (phy == 5'h11);
    eng_hi = {phy, 3'b101} ^ rg[15:8];
    eng_lo = ~wd[7:0] ^ {3'b000, dev};
    build_exp(w, c45, phy, dev, rg, wd);
    failed = !blocked && nk >= 0 && nk < exp_n && exp_op[nk] == 3'd2;
    if (failed) begin exp_n = nk + 2; exp_op[nk+1] = 3'd5; exp_b[nk+1] = 8'h00; end
    if (blocked) exp_n = 0;
    exp_rd = w ? 16'h0000 : (blocked || failed) ? 16'hFFFF : {eng_hi, eng_lo};
    @(negedge clk);
    log_n = 0; nack_at = nk;
    req_write = w; req_c45 = c45; req_phy = phy; req_dev = dev; req_reg = rg; req_wdata = wd;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    if (!blocked) check(!req_ready, {tag, " R9 busy"}, 32'(req_ready), 0);
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    if (blocked) check(cyc == 1, {tag, " R2 latency"}, 32'(cyc), 1);
    seq_ok = (log_n == exp_n);
    for (int i = 0; i < 16; i++)
      if (i < exp_n && i < log_n && (log_op[i] != exp_op[i] || (exp_op[i] == 3'd2 && log_b[i] != exp_b[i])))
        seq_ok = 0;
    check(seq_ok, {tag, " R1 R3 R4 R5 R6 R8 sequence"}, 32'(log_n), 32'(exp_n));
    check(rdata == exp_rd, {tag, " R7 rdata"}, 32'(rdata), 32'(exp_rd));
    check(err == failed, {tag, " R8 err"}, 32'(err), 32'(failed));
    @(negedge clk);
    check(!done && req_ready, {tag, " R9 done pulse"}, 32'(done), 0);
    nack_at = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !done && !err && !cmd_valid && rdata == 16'h0, "R10 reset",
          {req_ready, done, err, cmd_valid, rdata}, 32'h8_0000);
    for (int p = 0; p < 32; p++)
      for (int m = 0; m < 4; m++)
        run(m[0], m[1], 5'(p), 5'(p * 3 + 1), 16'(p * 16'h0913 + 16'h5A0C),
            16'(p * 16'h1F07 ^ 16'hC3A5), -1, (p == 16 || p == 17) ? "R2" : "R3R4R5R6");
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 10; k++)
        run(m[0], m[1], 5'd3, 5'd30, 16'hBEEF, 16'h1234, k, "R8 nack");
    run(1'b0, 1'b0, 5'h1F, 5'd0, 16'h00FF, 16'h0, -1, "R1 top phy");
    run(1'b0, 1'b1, 5'h11, 5'd7, 16'h0001, 16'h0, 2, "R2 nack ignored");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule